// File: doc/BRIEF.md
# Synchronous Transmit CRC Sequencer

This block is the transmit end of a synchronous serial channel, together with its 16-bit check-value generator. Characters written into a one-deep holding buffer are moved into a shifter at character boundaries and sent one bit per clock, least significant bit first. Each data bit that leaves the shifter is folded into a 16-bit CRC register. Whether a character is folded in is decided by a flag captured when that character is written into the buffer.

When a character boundary arrives and the buffer is empty, the transmitter has underrun. What it sends next depends on a one-bit idle/CRC latch. With the latch clear, it sends the 16 accumulated check bits, most significant first, and then sets the latch. With the latch set, it sends copies of the idle character (a sync pattern or a flag). The latch comes out of reset set, and a dedicated command clears it before each frame.

Two commands prepare a frame. One resets the generator: it loads all zeros in character mode and all ones in bit-oriented mode. The other clears the latch. The generator polynomial is selected by a pin, except that bit-oriented mode always uses x^16+x^12+x^5+1.

Top module: `tx_crc_seq`

## Requirements
- R1: While rst_ni is low, txd_o is 1, latch_o is 1, buf_empty_o is 1 and latch_set_o is 0.
- R2: In character mode (bit_mode_i=0), poly_sel_i=0 selects the polynomial 0x1021 (x^16+x^12+x^5+1), and poly_sel_i=1 selects 0x8005 (x^16+x^15+x^2+1). The update for each bit b is fb=crc[15]^b, then crc=(crc<<1)^(fb?poly:0).
- R3: A gen_reset_i pulse loads 0x0000 into the CRC register when bit_mode_i=0, and 0xFFFF when bit_mode_i=1.
- R4: With bit_mode_i=1, the polynomial 0x1021 is used whatever the value of poly_sel_i.
- R5: The value of crc_en_i in the cycle of a load_i pulse decides whether that character's bits are folded into the CRC. Changing crc_en_i in later cycles has no effect on that character.
- R6: A character boundary with the buffer empty and the latch clear starts the 16 CRC bits, most significant bit first, directly after the last data bit. The latch is set at the edge that ends the 16th bit.
- R7: A character boundary with the buffer empty and the latch set sends idle_char_i, least significant bit first. After reset, with no clear command, only idle characters are sent.
- R8: latch_clr_i clears the latch at the next edge. A clear with no data loaded still produces the 16-bit check value at the next boundary.
- R9: buf_empty_o is 0 throughout the 16 CRC bit times.
- R10: latch_set_o is high for exactly one cycle, the first cycle in which latch_o reads 1 after a CRC has been sent.
- R11: Character boundaries fall every 8 clocks, starting at the first edge after reset. A character loaded during a character time is sent from the next boundary, one data bit per clock, least significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one line bit per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_mode_i | input | 1 | 1 = bit-oriented (flag-framed) mode, 0 = character mode |
| poly_sel_i | input | 1 | Polynomial select in character mode |
| crc_en_i | input | 1 | Include-in-CRC flag, captured with load_i |
| load_i | input | 1 | Writes load_data_i into the holding buffer |
| load_data_i | input | 8 | Character to send |
| idle_char_i | input | 8 | Sync or flag character sent on underrun when the latch is set |
| gen_reset_i | input | 1 | Reset-generator command |
| latch_clr_i | input | 1 | Clear-idle/CRC-latch command |
| txd_o | output | 1 | Serial line bit |
| buf_empty_o | output | 1 | Holding buffer empty, held low while the CRC is sent |
| latch_o | output | 1 | Idle/CRC latch state |
| latch_set_o | output | 1 | One-cycle pulse when the latch becomes set |

## Verification
The bench counts clock edges from the release of reset, so it knows every character boundary. A load, clear or generator-reset pulse is driven in the cycle that sits 7 edges before the boundary it targets. After the boundary edge at cycle B, each line bit is sampled at the falling edge: data from B to B+15, check bits from B+16 to B+31, and idle from B+32. latch_set_o and latch_o are due in the falling edge after B+32. buf_empty_o and latch_o are checked in every CRC bit time. The include flag is inverted one cycle after each load, which shows that only the captured value counts.

// File: rtl/tx_crc_pkg.sv
package tx_crc_pkg;
  localparam int CRC_W = 16;
  localparam logic [CRC_W-1:0] POLY_CCITT = 16'h1021;
  localparam logic [CRC_W-1:0] POLY_ALT   = 16'h8005;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_DATA = 2'd1,
    SLOT_CRC  = 2'd2
  } slot_e;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                input logic b,
                                                input logic [CRC_W-1:0] poly);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/tx_crc_reg.sv
module tx_crc_reg
  import tx_crc_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY0 = POLY_CCITT,
  parameter logic [CRC_W-1:0] POLY1 = POLY_ALT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic preset_i,
  input  logic bit_mode_i,
  input  logic poly_sel_i,
  input  logic upd_i,
  input  logic bit_i,
  input  logic shift_i,
  output logic msb_o
);
  logic [CRC_W-1:0] crc_q, crc_d, poly;

  // bit-oriented mode is tied to the first polynomial
  assign poly = (bit_mode_i || !poly_sel_i) ? POLY0 : POLY1;

  always_comb begin
    crc_d = crc_q;
    if (preset_i)     crc_d = bit_mode_i ? '1 : '0;
    else if (upd_i)   crc_d = crc_step(crc_q, bit_i, poly);
    else if (shift_i) crc_d = {crc_q[CRC_W-2:0], 1'b0}; // no feedback on send
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) crc_q <= '0;
    else         crc_q <= crc_d;

  assign msb_o = crc_q[CRC_W-1];
endmodule

// File: rtl/tx_idle_latch.sv
module tx_idle_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  output logic latch_o,
  output logic set_pulse_o
);
  logic latch_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      latch_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= set_i && !clr_i && !latch_q;
      if (clr_i)      latch_q <= 1'b0;
      else if (set_i) latch_q <= 1'b1;
    end

  assign latch_o     = latch_q;
  assign set_pulse_o = pulse_q;
endmodule

// File: rtl/tx_char_seq.sv
module tx_char_seq
  import tx_crc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CHAR_W-1:0] data_i,
  input  logic              crc_en_i,
  input  logic [CHAR_W-1:0] idle_char_i,
  input  logic              latch_i,
  input  logic              crc_msb_i,
  output logic              txd_o,
  output logic              buf_empty_o,
  output logic              upd_o,
  output logic              data_bit_o,
  output logic              shift_o,
  output logic              crc_done_o,
  output logic              crc_active_o
);
  localparam int MAX_LEN = (CRC_W > CHAR_W) ? CRC_W : CHAR_W;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  slot_e             kind_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CHAR_W-1:0] sh_q, buf_q;
  logic              inc_q, buf_full_q, buf_inc_q;
  logic              fetch, latch_eff;

  assign fetch     = (cnt_q <= CNT_W'(1));
  assign latch_eff = latch_i || (kind_q == SLOT_CRC);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      kind_q     <= SLOT_IDLE;
      cnt_q      <= '0;
      sh_q       <= '1;
      inc_q      <= 1'b0;
      buf_q      <= '0;
      buf_full_q <= 1'b0;
      buf_inc_q  <= 1'b0;
    end else begin
      if (fetch) begin
        if (buf_full_q) begin
          kind_q     <= SLOT_DATA;
          sh_q       <= buf_q;
          inc_q      <= buf_inc_q;
          cnt_q      <= CNT_W'(CHAR_W);
          buf_full_q <= 1'b0;
        end else if (!latch_eff) begin
          kind_q <= SLOT_CRC;
          cnt_q  <= CNT_W'(CRC_W);
        end else begin
          kind_q <= SLOT_IDLE;
          sh_q   <= idle_char_i;
          cnt_q  <= CNT_W'(CHAR_W);
        end
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
        sh_q  <= {1'b1, sh_q[CHAR_W-1:1]};
      end
      if (load_i) begin
        buf_q      <= data_i;
        buf_inc_q  <= crc_en_i;
        buf_full_q <= 1'b1;
      end
    end

  assign crc_active_o = (kind_q == SLOT_CRC) && (cnt_q != '0);
  assign txd_o        = crc_active_o ? crc_msb_i : ((cnt_q == '0) ? 1'b1 : sh_q[0]);
  assign buf_empty_o  = !buf_full_q && !crc_active_o;
  assign upd_o        = (kind_q == SLOT_DATA) && (cnt_q != '0) && inc_q;
  assign data_bit_o   = sh_q[0];
  assign shift_o      = crc_active_o;
  assign crc_done_o   = (kind_q == SLOT_CRC) && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/tx_crc_seq.sv
module tx_crc_seq
  import tx_crc_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_mode_i,
  input  logic              poly_sel_i,
  input  logic              crc_en_i,
  input  logic              load_i,
  input  logic [CHAR_W-1:0] load_data_i,
  input  logic [CHAR_W-1:0] idle_char_i,
  input  logic              gen_reset_i,
  input  logic              latch_clr_i,
  output logic              txd_o,
  output logic              buf_empty_o,
  output logic              latch_o,
  output logic              latch_set_o
);
  logic upd, data_bit, shift, crc_done, crc_active, crc_msb;

  tx_char_seq #(.CHAR_W(CHAR_W)) i_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load_i),
    .data_i       (load_data_i),
    .crc_en_i     (crc_en_i),
    .idle_char_i  (idle_char_i),
    .latch_i      (latch_o),
    .crc_msb_i    (crc_msb),
    .txd_o        (txd_o),
    .buf_empty_o  (buf_empty_o),
    .upd_o        (upd),
    .data_bit_o   (data_bit),
    .shift_o      (shift),
    .crc_done_o   (crc_done),
    .crc_active_o (crc_active)
  );

  tx_crc_reg i_crc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .preset_i   (gen_reset_i),
    .bit_mode_i (bit_mode_i),
    .poly_sel_i (poly_sel_i),
    .upd_i      (upd),
    .bit_i      (data_bit),
    .shift_i    (shift),
    .msb_o      (crc_msb)
  );

  tx_idle_latch i_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (latch_clr_i),
    .set_i       (crc_done),
    .latch_o     (latch_o),
    .set_pulse_o (latch_set_o)
  );
endmodule

// File: rtl/tx_crc_seq_chk.sv
module tx_crc_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic latch_clr_i,
  input logic latch_o,
  input logic latch_set_o,
  input logic buf_empty_o,
  input logic crc_active
);
  AST_LATCH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_clr_i |=> !latch_o); // R8
  AST_SET_AFTER_CRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_o) |-> $past(crc_active)); // R6
  AST_SET_PULSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(latch_o) |-> latch_set_o); // R10
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_set_o |=> !latch_set_o); // R10
  AST_FULL_DURING_CRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_set_o |-> $past(!buf_empty_o)); // R9
endmodule

bind tx_crc_seq tx_crc_seq_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .latch_clr_i (latch_clr_i),
  .latch_o     (latch_o),
  .latch_set_o (latch_set_o),
  .buf_empty_o (buf_empty_o),
  .crc_active  (crc_active)
);

// File: tb/test_tx_crc_seq.sv
`timescale 1ns/1ps
module test_tx_crc_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_mode = 1'b0, poly_sel = 1'b0, crc_en = 1'b0, load = 1'b0;
  logic gen_reset = 1'b0, latch_clr = 1'b0;
  logic [7:0] load_data = '0, idle_char = 8'h16;
  logic txd, buf_empty, latch, latch_set;
  int cyc = 0, checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk)
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;

  tx_crc_seq i_tx_crc_seq (
    .clk_i(clk), .rst_ni(rst_n), .bit_mode_i(bit_mode), .poly_sel_i(poly_sel),
    .crc_en_i(crc_en), .load_i(load), .load_data_i(load_data),
    .idle_char_i(idle_char), .gen_reset_i(gen_reset), .latch_clr_i(latch_clr),
    .txd_o(txd), .buf_empty_o(buf_empty), .latch_o(latch), .latch_set_o(latch_set)
  );

  // {bit_mode, poly_sel, inc0, inc1, char0, char1}
  localparam int NV = 6;
  localparam logic [19:0] VEC [NV] = '{
    {4'b0011, 8'h41, 8'h42},
    {4'b0111, 8'h41, 8'h42},
    {4'b1111, 8'hA5, 8'h3C},
    {4'b0001, 8'h41, 8'h42},
    {4'b0110, 8'hFF, 8'h00},
    {4'b1000, 8'h00, 8'h00}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic to_neg(input int k);
    do @(negedge clk); while (cyc != k + 1);
  endtask

  function automatic logic [15:0] model(input logic bm, input logic ps,
                                        input logic i0, input logic i1,
                                        input logic [7:0] c0, input logic [7:0] c1);
    logic [15:0] c, p;
    logic [7:0] ch;
    logic fb;
    c = bm ? 16'hFFFF : 16'h0000;
    p = (bm || !ps) ? 16'h1021 : 16'h8005;
    for (int n = 0; n < 2; n++) begin
      ch = (n == 0) ? c0 : c1;
      if ((n == 0) ? i0 : i1)
        for (int i = 0; i < 8; i++) begin
          fb = c[15] ^ ch[i];
          c = {c[14:0], 1'b0} ^ (fb ? p : 16'h0);
        end
    end
    return c;
  endfunction

  task automatic run_frame(input int b, input logic [19:0] v, input string tag);
    logic bm, ps, i0, i1;
    logic [7:0] c0, c1, idl;
    logic [15:0] exp_crc;
    int bad_empty, bad_latch;
    {bm, ps, i0, i1, c0, c1} = v;
    idl = bm ? 8'h7E : 8'h16;
    exp_crc = model(bm, ps, i0, i1, c0, c1);
    to_neg(b - 7);
    bit_mode = bm; poly_sel = ps; idle_char = idl;
    load = 1'b1; load_data = c0; crc_en = i0; gen_reset = 1'b1; latch_clr = 1'b1;
    to_neg(b - 6);
    load = 1'b0; gen_reset = 1'b0; latch_clr = 1'b0; crc_en = ~i0; // R5 late change
    for (int k = 0; k < 16; k++) begin
      to_neg(b + k);
      chk({tag, " R11 data bit"}, 16'(txd), 16'((k < 8) ? c0[k] : c1[k-8]));
      if (k == 0) begin load = 1'b1; load_data = c1; crc_en = i1; end
      if (k == 1) begin load = 1'b0; crc_en = ~i1; end
    end
    bad_empty = 0; bad_latch = 0;
    for (int k = 0; k < 16; k++) begin
      to_neg(b + 16 + k);
      chk({tag, " R6 R2 R3 R4 R5 crc bit"}, 16'(txd), 16'(exp_crc[15-k]));
      if (buf_empty !== 1'b0) bad_empty++;
      if (latch !== 1'b0) bad_latch++;
    end
    chk({tag, " R9 buf_empty high during crc"}, 16'(bad_empty), 16'd0);
    chk({tag, " R8 latch not clear during crc"}, 16'(bad_latch), 16'd0);
    to_neg(b + 32);
    chk({tag, " R10 set pulse"}, 16'(latch_set), 16'd1);
    chk({tag, " R6 latch set after crc"}, 16'(latch), 16'd1);
    chk({tag, " R7 idle bit"}, 16'(txd), 16'(idl[0]));
    for (int k = 1; k < 8; k++) begin
      to_neg(b + 32 + k);
      if (k == 1) chk({tag, " R10 pulse one cycle"}, 16'(latch_set), 16'd0);
      chk({tag, " R7 idle bit"}, 16'(txd), 16'(idl[k]));
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 txd", 16'(txd), 16'd1);
    chk("R1 latch", 16'(latch), 16'd1);
    chk("R1 buf_empty", 16'(buf_empty), 16'd1);
    chk("R1 pulse", 16'(latch_set), 16'd0);
    rst_n = 1'b1;
    // underrun with latch set from reset: idle only
    for (int k = 0; k < 16; k++) begin
      to_neg(k);
      chk("R7 idle after reset", 16'(txd), 16'(idle_char[k % 8]));
      if (latch !== 1'b1 || latch_set !== 1'b0) chk("R7 latch stays set", {latch, latch_set}, 16'b10);
    end
    // table of frames
    for (int i = 0; i < NV; i++) run_frame(24 + 48 * i, VEC[i], $sformatf("vec%0d", i));
    // clear with no data: crc of preset value (bit mode, all ones)
    begin
      int b;
      b = 24 + 48 * NV;
      to_neg(b - 7);
      bit_mode = 1'b1; gen_reset = 1'b1; latch_clr = 1'b1;
      to_neg(b - 6);
      gen_reset = 1'b0; latch_clr = 1'b0;
      to_neg(b - 5);
      chk("R8 latch cleared by command", 16'(latch), 16'd0);
      for (int k = 0; k < 16; k++) begin
        to_neg(b + k);
        chk("R8 R3 preset crc sent", 16'(txd), 16'd1);
      end
      to_neg(b + 16);
      chk("R10 pulse after empty frame", 16'(latch_set), 16'd1);
      chk("R6 latch set after empty frame", 16'(latch), 16'd1);
    end
    // reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 txd mid reset", 16'(txd), 16'd1);
    chk("R1 latch mid reset", 16'(latch), 16'd1);
    chk("R1 buf_empty mid reset", 16'(buf_empty), 16'd1);
    chk("R1 pulse mid reset", 16'(latch_set), 16'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule